// File: doc/BRIEF.md
# JTAG Chain Scan Sequencer with Bypass Padding

This block is a JTAG master for a daisy chain of devices. It generates TCK from the system clock and drives TMS and TDI. It samples TDO and talks to one chosen device in the chain. The devices between the target and TDO are called the lead side. The devices between TDI and the target are called the trail side. For each scan, the caller gives the bit counts for both sides.

Those devices are assumed to hold the all-ones BYPASS instruction. In an IR scan, their positions are filled with ones. In a DR scan, each of them contributes one bypass bit. The sequencer walks the TAP controllers from Run-Test/Idle through the scan and back to Run-Test/Idle. It counts every shifted bit. It returns only the target's bits, right-aligned, with the padding removed.

A reset command walks every TAP through Test-Logic-Reset, which makes every device select its 32-bit identification register. After that, a plain DR scan of 32 bits per device reads every identification word in the chain. The word from the device nearest TDO comes out first.

Top module: `jtag_pad_scan`

## Requirements
- R1: A command with cmd_op = 0 (TAP reset) produces exactly six TCK cycles. TMS is high at the first five TCK rising edges and low at the sixth.
- R2: Let N = cmd_lead + cmd_len + cmd_trail.
  - A command with cmd_op = 2 (DR scan; code 3 behaves the same) produces 3+N+2 TCK cycles. TMS at successive rising edges is 1,0,0, then N shift edges with TMS high only on the last one, then 1,0.
  - A command with cmd_op = 1 (IR scan) produces 4+N+2 cycles, with the header 1,1,0,0 and the same shift and tail sequence.
- R3: During the N shift edges, TDI carries cmd_lead ones first, then cmd_data bit 0 upward for cmd_len bits, then cmd_trail ones.
- R4: TDO is sampled at each shift rising edge.
  - The first cmd_lead samples are discarded.
  - The next cmd_len samples are placed at cap_data[0] upward.
  - All other cap_data bits read zero.
- R5: cmd_ready is high only while no command is in progress, and a command is taken on a cycle with cmd_valid and cmd_ready both high. cmd_valid raised during a command is ignored. cap_valid pulses for exactly one cycle when the final TCK falls, and cap_data is valid from that cycle.
- R6: Each TCK half-period lasts clk_div+1 system clock cycles. TMS and TDI change only together with a falling TCK edge, or at command acceptance while TCK is low.
- R7: With N = 0, TMS is high at the Capture edge, going directly to Exit1. A DR scan then gives TMS 1,0,1,1,0 and an IR scan gives 1,1,0,1,1,0. The chain is left in Run-Test/Idle.
- R8: Whenever no command is in progress, TCK is low, TMS is low and TDI is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | 0 TAP reset, 1 IR scan, 2 or 3 DR scan |
| cmd_len | input | LEN_W | Target payload length in bits |
| cmd_lead | input | LEN_W | Padding bits for devices on the TDO side |
| cmd_trail | input | LEN_W | Padding bits for devices on the TDI side |
| cmd_data | input | PAY_W | Payload, bit 0 shifted first |
| clk_div | input | DIV_W | TCK half-period minus one, in clk cycles |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to chain |
| tdo | input | 1 | JTAG data from chain |
| cap_valid | output | 1 | One-cycle scan-complete strobe |
| cap_data | output | PAY_W | Target bits captured from TDO, right-aligned |

## Verification
The hardest case to reach from the ports is a scan whose total shift length is zero. In that case the TAP must jump from Capture straight to Exit1, and a one-step mistake leaves the chain stuck in Pause. The bench issues zero-length IR and DR scans against a behavioural two-device chain. It then proves the chain came back to Run-Test/Idle by running a DR scan through the bypass bits and checking that the data arrives delayed by exactly two positions. Trailing padding never reaches the capture window, so the bench also logs TDI at every TCK rise to check those bits directly.

// File: rtl/jps_pkg.sv
`timescale 1ns/1ps
package jps_pkg;
  localparam logic [1:0] OP_RESET = 2'd0;
  localparam logic [1:0] OP_IR    = 2'd1;
  localparam logic [1:0] OP_DR    = 2'd2;

  localparam int RESET_HIGH  = 5;
  localparam int RESET_STEPS = 6;
  localparam int TAIL_STEPS  = 2;

  // TCK cycles before the first shift edge.
  function automatic int hdr_steps(input logic [1:0] op);
    return (op == OP_IR) ? 4 : 3;
  endfunction

  // Total TCK cycles used by one command.
  function automatic int total_steps(input logic [1:0] op, input int n);
    if (op == OP_RESET) return RESET_STEPS;
    return hdr_steps(op) + n + TAIL_STEPS;
  endfunction

  // TMS level for TCK cycle st of a command with n shift bits.
  function automatic logic tms_at(input logic [1:0] op, input int st, input int n);
    int h;
    if (op == OP_RESET) return st < RESET_HIGH;
    h = hdr_steps(op);
    if (st == 0) return 1'b1;
    if (op == OP_IR && st == 1) return 1'b1;
    if (st < h - 1) return 1'b0;
    if (st == h - 1) return n == 0;
    if (st < h + n) return st == h + n - 1;
    return st == h + n;
  endfunction
endpackage

// File: rtl/jps_tck_gen.sv
`timescale 1ns/1ps
module jps_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             edge_hit;

  assign edge_hit = run && (cnt_q == div);
  assign rise     = edge_hit && !tck_q;
  assign fall     = edge_hit && tck_q;
  assign tck      = tck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (edge_hit) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  a_r6_rise_goes_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> tck_q);
  a_r6_fall_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !tck_q);
endmodule

// File: rtl/jps_capture.sv
`timescale 1ns/1ps
module jps_capture #(
  parameter int LEN_W  = 8,
  parameter int PAY_W  = 256,
  parameter int STEP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [STEP_W-1:0] idx,
  input  logic [LEN_W-1:0]  lead,
  input  logic [LEN_W-1:0]  len,
  input  logic              tdo,
  output logic [PAY_W-1:0]  cap
);
  logic [PAY_W-1:0]  cap_q;
  logic [STEP_W-1:0] win_lo, win_hi;
  logic [LEN_W-1:0]  pos;
  logic              keep;

  assign win_lo = STEP_W'(lead);
  assign win_hi = win_lo + STEP_W'(len);
  assign keep   = sample && (idx >= win_lo) && (idx < win_hi);
  assign pos    = LEN_W'(idx - win_lo);
  assign cap    = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (clear) cap_q <= '0;
    else if (keep)  cap_q[pos] <= tdo;
  end

  // R4: the capture holds still outside the target window
  a_r4_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep && !clear) |=> $stable(cap_q));
endmodule

// File: rtl/jtag_pad_scan.sv
`timescale 1ns/1ps
module jtag_pad_scan #(
  parameter int LEN_W = 8,
  parameter int DIV_W = 8,
  parameter int PAY_W = 2**LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [LEN_W-1:0] cmd_lead,
  input  logic [LEN_W-1:0] cmd_trail,
  input  logic [PAY_W-1:0] cmd_data,
  input  logic [DIV_W-1:0] clk_div,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic             cap_valid,
  output logic [PAY_W-1:0] cap_data
);
  import jps_pkg::*;

  localparam int STEP_W = LEN_W + 3;

  logic              busy_q, fin_q, done_q, tms_q, tdi_q;
  logic [1:0]        op_q;
  logic [LEN_W-1:0]  len_q, lead_q;
  logic [STEP_W-1:0] n_q, st_q;
  logic [PAY_W-1:0]  data_q;

  logic              accept, rise, fall, tck_w;
  logic [STEP_W-1:0] n_cmd, hdr_w, tot_w, last_w, idx_w;
  logic              in_shift, last_shift, sample;

  // TDI level for TCK cycle st: lead ones, payload, trail ones.
  function automatic logic tdi_for(input logic [1:0] op, input int st, input int ld,
                                   input int ln, input int nt, input logic [PAY_W-1:0] d);
    int i;
    if (op == OP_RESET) return 1'b1;
    i = st - hdr_steps(op);
    if (i < 0 || i >= nt) return 1'b1;
    if (i < ld || i >= ld + ln) return 1'b1;
    return d[LEN_W'(i - ld)];
  endfunction

  assign accept     = cmd_valid && !busy_q;
  assign cmd_ready  = !busy_q;
  assign n_cmd      = STEP_W'(cmd_lead) + STEP_W'(cmd_len) + STEP_W'(cmd_trail);
  assign hdr_w      = STEP_W'(hdr_steps(op_q));
  assign tot_w      = STEP_W'(total_steps(op_q, int'(n_q)));
  assign last_w     = tot_w - STEP_W'(1);
  assign in_shift   = (op_q != OP_RESET) && (st_q >= hdr_w) && (st_q < hdr_w + n_q);
  assign last_shift = in_shift && (st_q == hdr_w + n_q - STEP_W'(1));
  assign idx_w      = st_q - hdr_w;
  assign sample     = busy_q && rise && in_shift;

  jps_tck_gen #(.DIV_W(DIV_W)) tck_gen_i (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .div(clk_div),
    .tck(tck_w), .rise(rise), .fall(fall)
  );

  jps_capture #(.LEN_W(LEN_W), .PAY_W(PAY_W), .STEP_W(STEP_W)) capture_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample), .idx(idx_w),
    .lead(lead_q), .len(len_q), .tdo(tdo), .cap(cap_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_RESET;
      len_q  <= '0;
      lead_q <= '0;
      n_q    <= '0;
      data_q <= '0;
      st_q   <= '0;
      tms_q  <= 1'b0;
      tdi_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        fin_q  <= 1'b0;
        op_q   <= cmd_op;
        len_q  <= cmd_len;
        lead_q <= cmd_lead;
        n_q    <= n_cmd;
        data_q <= cmd_data;
        st_q   <= '0;
        tms_q  <= tms_at(cmd_op, 0, int'(n_cmd));
        tdi_q  <= tdi_for(cmd_op, 0, int'(cmd_lead), int'(cmd_len), int'(n_cmd), cmd_data);
      end else if (busy_q) begin
        if (rise) begin
          if (st_q == last_w) fin_q <= 1'b1;
          else                st_q  <= st_q + STEP_W'(1);
        end
        if (fall) begin
          if (fin_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            tms_q  <= 1'b0;
            tdi_q  <= 1'b1;
          end else begin
            tms_q <= tms_at(op_q, int'(st_q), int'(n_q));
            tdi_q <= tdi_for(op_q, int'(st_q), int'(lead_q), int'(len_q), int'(n_q), data_q);
          end
        end
      end
    end
  end

  assign tck       = tck_w;
  assign tms       = tms_q;
  assign tdi       = tdi_q;
  assign cap_valid = done_q;

  a_r6_tms_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (tms_q != $past(tms_q)) |-> ($past(fall) || $past(accept)));
  a_r6_tdi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (tdi_q != $past(tdi_q)) |-> ($past(fall) || $past(accept)));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> (!tck_w && !tms_q && tdi_q));
  a_r2_exit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && last_shift) |-> tms_q);
  a_r2_stay_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && in_shift && !last_shift) |-> !tms_q);
endmodule

// File: tb/jps_tap_model.sv
`timescale 1ns/1ps
module jps_tap_model #(
  parameter int          IR_LEN = 6,
  parameter logic [31:0] IDCODE = 32'h0,
  parameter logic [IR_LEN-1:0] ID_OP = '0
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic tdo
);
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIR, CIR, SHI, E1I, PIR, E2I, UIR} tap_e;
  tap_e st = TLR;
  logic [IR_LEN-1:0] ir = ID_OP;
  logic [IR_LEN-1:0] ir_sh = '0;
  logic [31:0]       dr_sh = '0;
  logic              byp = 1'b0;
  logic              sel_id;

  assign sel_id = (ir == ID_OP);

  function automatic tap_e nxt(input tap_e s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    case (st)
      TLR: ir <= ID_OP;
      CDR: begin dr_sh <= IDCODE; byp <= 1'b0; end
      SHD: begin dr_sh <= {tdi, dr_sh[31:1]}; byp <= tdi; end
      CIR: ir_sh <= IR_LEN'(1);
      SHI: ir_sh <= {tdi, ir_sh[IR_LEN-1:1]};
      UIR: ir <= ir_sh;
      default: ;
    endcase
    st <= nxt(st, tms);
  end

  always @(negedge tck) begin
    if (st == SHD)      tdo <= sel_id ? dr_sh[0] : byp;
    else if (st == SHI) tdo <= ir_sh[0];
  end
endmodule

// File: tb/jtag_pad_scan_tb_top.sv
`timescale 1ns/1ps
module jtag_pad_scan_tb_top;
  localparam int LEN_W = 8;
  localparam int DIV_W = 8;
  localparam int PAY_W = 256;
  localparam logic [31:0] ID_A = 32'h41C10093;
  localparam logic [31:0] ID_B = 32'h15045093;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [LEN_W-1:0] cmd_len = '0, cmd_lead = '0, cmd_trail = '0;
  logic [PAY_W-1:0] cmd_data = '0;
  logic [DIV_W-1:0] clk_div = 8'd1;
  logic tck, tms, tdi, tdo, a_tdo, cap_valid;
  logic [PAY_W-1:0] cap_data;

  int n_chk = 0, n_bad = 0, fin_flag = 0;
  int rise_cnt = 0, cyc = 0, rise_cyc = 0, prev_rise_cyc = 0, r6_viol = 0;
  logic [4095:0] tms_log, tdi_log;
  logic p_tms = 1'b0, p_tdi = 1'b1;

  always #2 clk = ~clk;

  jtag_pad_scan #(.LEN_W(LEN_W), .DIV_W(DIV_W), .PAY_W(PAY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_lead(cmd_lead), .cmd_trail(cmd_trail),
    .cmd_data(cmd_data), .clk_div(clk_div), .tck(tck), .tms(tms), .tdi(tdi),
    .tdo(tdo), .cap_valid(cap_valid), .cap_data(cap_data)
  );

  // Chain: TDI -> device A (6-bit IR) -> device B (8-bit IR) -> TDO
  jps_tap_model #(.IR_LEN(6), .IDCODE(ID_A), .ID_OP(6'b001001)) dev_a (
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(a_tdo));
  jps_tap_model #(.IR_LEN(8), .IDCODE(ID_B), .ID_OP(8'hFE)) dev_b (
    .tck(tck), .tms(tms), .tdi(a_tdo), .tdo(tdo));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge tck) begin
    tms_log[rise_cnt[11:0]] <= tms;
    tdi_log[rise_cnt[11:0]] <= tdi;
    rise_cnt <= rise_cnt + 1;
    prev_rise_cyc <= rise_cyc;
    rise_cyc <= cyc;
  end

  // R6: TMS/TDI must never change while TCK is high
  always @(negedge clk) begin
    if ((tms !== p_tms || tdi !== p_tdi) && tck === 1'b1) r6_viol <= r6_viol + 1;
    p_tms <= tms;
    p_tdi <= tdi;
  end

  task automatic chk(input string req, input logic [PAY_W-1:0] act, input logic [PAY_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PAY_W-1:0] log_bits(input logic [4095:0] lg, input int start, input int cnt);
    logic [PAY_W-1:0] v = '0;
    for (int k = 0; k < cnt; k++) v[k] = lg[(start + k) % 4096];
    return v;
  endfunction

  int base;
  // Runs one command; returns capture and the number of TCK rises.
  task automatic scan(input logic [1:0] op, input int ln, input int ld, input int tr,
                      input logic [PAY_W-1:0] d, output logic [PAY_W-1:0] res, output int rises);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_len = LEN_W'(ln); cmd_lead = LEN_W'(ld); cmd_trail = LEN_W'(tr);
    cmd_data = d; base = rise_cnt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cap_valid) @(negedge clk);
    res = cap_data;
    rises = rise_cnt - base;
    @(negedge clk);
    chk("R5 cap_valid single pulse", {255'd0, cap_valid}, '0);
    chk("R8 idle levels tck/tms/tdi", {253'd0, tck, tms, tdi}, 256'd1);
  endtask

  task automatic t_reset_state();
    chk("R5 ready after reset", {255'd0, cmd_ready}, 256'd1);
    chk("R8 reset levels tck/tms/tdi", {253'd0, tck, tms, tdi}, 256'd1);
    chk("R5 no strobe after reset", {255'd0, cap_valid}, '0);
  endtask

  task automatic t_tap_reset();
    logic [PAY_W-1:0] r; int n;
    scan(2'd0, 0, 0, 0, '0, r, n);
    chk("R1 reset cycle count", PAY_W'(n), PAY_W'(6));
    chk("R1 reset tms pattern", log_bits(tms_log, base, 6), PAY_W'(6'b011111));
  endtask

  task automatic t_chain_ids();
    logic [PAY_W-1:0] r; int n;
    scan(2'd2, 64, 0, 0, '0, r, n);
    chk("R4 both idcodes, TDO-side first", r, {192'd0, ID_A, ID_B});
    chk("R2 DR cycle count 3+64+2", PAY_W'(n), PAY_W'(69));
    chk("R2 DR header tms", log_bits(tms_log, base, 3), PAY_W'(3'b001));
    chk("R2 DR last shift and tail tms", log_bits(tms_log, base + 65, 4), PAY_W'(4'b0110));
  endtask

  task automatic t_ids_offset();
    logic [PAY_W-1:0] r; int n;
    scan(2'd2, 32, 32, 0, '0, r, n);
    chk("R4 lead 32 skips TDO-side device", r, PAY_W'(ID_A));
    scan(2'd2, 32, 0, 32, '0, r, n);
    chk("R4 trail 32 keeps TDO-side device", r, PAY_W'(ID_B));
  endtask

  task automatic t_target_a();
    logic [PAY_W-1:0] r; int n;
    scan(2'd1, 6, 8, 0, PAY_W'(6'b001001), r, n);
    chk("R4 IR capture of target A", r, PAY_W'(6'b000001));
    chk("R2 IR cycle count 4+14+2", PAY_W'(n), PAY_W'(20));
    chk("R2 IR header tms", log_bits(tms_log, base, 4), PAY_W'(4'b0011));
    chk("R3 lead ones then payload", log_bits(tdi_log, base + 4, 14), PAY_W'({6'b001001, 8'hFF}));
    scan(2'd2, 32, 1, 0, '0, r, n);
    chk("R4 target A idcode past one bypass bit", r, PAY_W'(ID_A));
  endtask

  task automatic t_target_b();
    logic [PAY_W-1:0] r; int n;
    scan(2'd1, 8, 0, 6, PAY_W'(8'hFE), r, n);
    chk("R4 IR capture of target B", r, PAY_W'(8'h01));
    chk("R3 payload then trail ones", log_bits(tdi_log, base + 4, 14), PAY_W'({6'h3F, 8'hFE}));
    scan(2'd3, 32, 0, 1, '0, r, n);
    chk("R4 target B idcode with trail bit", r, PAY_W'(ID_B));
  endtask

  task automatic t_bypass_all();
    logic [PAY_W-1:0] r; int n;
    scan(2'd1, 14, 0, 0, PAY_W'(14'h3FFF), r, n);
    chk("R4 IR capture of whole chain", r, PAY_W'({6'b000001, 8'b00000001}));
    scan(2'd2, 10, 0, 0, PAY_W'(10'b1011001110), r, n);
    chk("R3 data through two bypass bits", r, PAY_W'({8'b11001110, 2'b00}));
    scan(2'd2, 4, 3, 0, '0, r, n);
    chk("R3 lead ones visible after bypass", r, PAY_W'(4'b0011));
  endtask

  task automatic t_busy_ignore();
    logic [PAY_W-1:0] r; int n;
    scan(2'd1, 6, 8, 0, PAY_W'(6'b001001), r, n);
    fork
      scan(2'd2, 32, 1, 0, '0, r, n);
      begin
        repeat (30) @(negedge clk);
        chk("R5 not ready while busy", {255'd0, cmd_ready}, '0);
        cmd_op = 2'd0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk("R5 busy request ignored, result", r, PAY_W'(ID_A));
    chk("R5 busy request ignored, length", PAY_W'(n), PAY_W'(38));
  endtask

  task automatic t_zero_len();
    logic [PAY_W-1:0] r; int n;
    scan(2'd1, 14, 0, 0, PAY_W'(14'h3FFF), r, n);
    scan(2'd2, 0, 0, 0, '0, r, n);
    chk("R7 zero DR cycle count", PAY_W'(n), PAY_W'(5));
    chk("R7 zero DR tms", log_bits(tms_log, base, 5), PAY_W'(5'b01101));
    chk("R7 zero DR capture empty", r, '0);
    scan(2'd2, 10, 0, 0, PAY_W'(10'b0111010101), r, n);
    chk("R7 chain usable after zero DR", r, PAY_W'({8'b11010101, 2'b00}));
    scan(2'd1, 0, 0, 0, '0, r, n);
    chk("R7 zero IR cycle count", PAY_W'(n), PAY_W'(6));
    chk("R7 zero IR tms", log_bits(tms_log, base, 6), PAY_W'(6'b011011));
    scan(2'd2, 10, 0, 0, PAY_W'(10'b1100110011), r, n);
    chk("R7 chain usable after zero IR", r, PAY_W'({8'b00110011, 2'b00}));
  endtask

  task automatic t_divider();
    logic [PAY_W-1:0] r; int n;
    clk_div = 8'd3;
    scan(2'd2, 32, 0, 32, '0, r, n);
    chk("R6 TCK period at divider 3", PAY_W'(rise_cyc - prev_rise_cyc), PAY_W'(8));
    chk("R6 result unaffected by divider", r, PAY_W'(ID_B));
    clk_div = 8'd0;
    scan(2'd2, 32, 32, 0, '0, r, n);
    chk("R6 TCK period at divider 0", PAY_W'(rise_cyc - prev_rise_cyc), PAY_W'(2));
    chk("R6 result at fastest TCK", r, PAY_W'(ID_A));
    clk_div = 8'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (fin_flag == 0) begin
      fin_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tap_reset();
    t_chain_ids();
    t_tap_reset();
    t_ids_offset();
    t_target_a();
    t_target_b();
    t_bypass_all();
    t_busy_ignore();
    t_zero_len();
    t_tap_reset();
    t_divider();
    chk("R6 TMS/TDI changes only with TCK low", PAY_W'(r6_viol), '0);
    if (fin_flag == 0) begin
      fin_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule